// File: doc/BRIEF.md
# Write-Protected GPIO Pin Function Controller

A memory-mapped controller for a parameterised number of ports, each with eight pins. Every pin is in one of four states. It can idle in high impedance with its input path blocked. It can be a GPIO input or a GPIO output. It can also be handed to a peripheral, which is picked by an 8-bit per-pin function code. Software reaches the registers over a 16-bit bus that carries a halfword address, a write enable and two byte strobes. Read data is combinational from the address. On the pad side, each pin has an output value, an output enable and an input. Each pin also presents its function code and a peripheral-mode flag, which an external multiplexer uses.

The function-code registers are guarded by a two-bit protect register. A lock bit blocks changes to a write-enable bit. While the write-enable bit is clear, every write to a function code is dropped. Opening the guard takes two writes: first clear the lock bit, then set the enable bit. The guard is closed again with two writes in the same way.

Pin index `n` belongs to port `n/8`, bit `n%8`. Byte address = halfword address * 2 + lane, where strobe bit 0 / data bits 7:0 are the even byte and strobe bit 1 / data bits 15:8 the odd byte.

Top module: `pinfunc_ctrl`

## Requirements
- R1: After reset every direction code is 00, output data, mode and all function codes are 0, the protect register reads 0x80, and `pad_oe`, `pin_periph` and `pin_func` are all zero.
- R2: `pad_oe` for a pin is 1 exactly when its mode bit is 0 and its direction code is 11; `pad_out` follows the output data bit; `pad_oe` and `pin_periph` are never both 1 for a pin.
- R3: The direction bytes sit at byte address 2*port and 2*port+1; pin p of a port uses bits 2p+1:2p of that port's 16-bit value (10 = input, 11 = output, 00 = idle high impedance); all bits read back as written.
- R4: Input data for port k reads at byte address 0x060+k, bit p = pad level of pin p after a two-flop synchroniser (a pad change first shows after the second rising edge), but only when the pin's direction code is 10 or its mode bit is 1; otherwise the bit reads 0. Writes there have no effect.
- R5: While the protect enable bit (bit 6 of byte 0x2FF) is 0, writes to any function-code byte leave it unchanged.
- R6: Byte 0x2FF holds a lock bit in bit 7 and the enable bit in bit 6 and reads as {lock, enable, 000000}; a write always loads the lock bit from data bit 7, but loads the enable bit from data bit 6 only if the lock bit was 0 before that write.
- R7: Writing 0x00 then 0x40 to byte 0x2FF opens the function-code registers (reads 0x40); writing 0x00 then 0x80 closes them again (reads 0x80).
- R8: Mode bits sit at byte address 0x080+port, bit p for pin p; a 1 raises `pin_periph` for that pin, holds its `pad_oe` low, and `pin_func` carries its function code.
- R9: Output data for port k is at byte address 0x040+k, one bit per pin, read back as written.
- R10: Reads of any byte address not listed in R3 to R9 and R11 for the built port count return 0, and writes to them change no register.
- R11: Function code of pin index n is at byte address 0x200+n, 8 bits wide, including the interrupt-select flag in bit 6, read back as written and presented on `pin_func[8n+7:8n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_addr | input | 11 | Halfword address |
| bus_we | input | 1 | Write enable |
| bus_be | input | 2 | Byte strobes (bit 0 even byte, bit 1 odd byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed halfword |
| pad_in | input | NPORT*8 | Pad input levels |
| pad_out | output | NPORT*8 | Pad output values |
| pad_oe | output | NPORT*8 | Pad output enables |
| pin_periph | output | NPORT*8 | Per-pin peripheral mode flag |
| pin_func | output | NPORT*64 | Per-pin function code, 8 bits each |

## Verification
The bench builds the block with NPORT = 3, which is 24 pins. With that setting, the first direction, output and function-code addresses beyond the last port are unmapped and can be reached, so the region boundaries in R10 are checked right at their edge. The small port count also lets one pin be driven through every combination of direction code and mode. The protect register is fixed at 0x2FF, so its full lock and unlock sequencing works the same as at the default size.

// File: rtl/pinfunc_ctrl.sv
module pinfunc_ctrl #(
  parameter int NPORT = 22
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [10:0]           bus_addr,
  input  logic                  bus_we,
  input  logic [1:0]            bus_be,
  input  logic [15:0]           bus_wdata,
  output logic [15:0]           bus_rdata,
  input  logic [NPORT*8-1:0]    pad_in,
  output logic [NPORT*8-1:0]    pad_out,
  output logic [NPORT*8-1:0]    pad_oe,
  output logic [NPORT*8-1:0]    pin_periph,
  output logic [NPORT*64-1:0]   pin_func
);
  localparam int NPIN      = NPORT * 8;
  localparam int DIR_BASE  = 'h000;
  localparam int OUT_BASE  = 'h040;
  localparam int IN_BASE   = 'h060;
  localparam int MODE_BASE = 'h080;
  localparam int FSEL_BASE = 'h200;
  localparam int WP_ADDR   = 'h2FF;

  logic [2*NPIN-1:0] dir_q;
  logic [NPIN-1:0]   out_q, mode_q, sync1_q, sync2_q, rd_en, in_vis;
  logic [8*NPIN-1:0] fsel_q;
  logic              b0wi_q, pfswe_q;
  int                ba [2];

  function automatic logic in_rng(int a, int base, int n);
    return (a >= base) && (a < base + n);
  endfunction

  always_comb begin
    ba[0] = int'({bus_addr, 1'b0});
    ba[1] = int'({bus_addr, 1'b1});
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pad_oe[i] = ~mode_q[i] & (dir_q[2*i +: 2] == 2'b11);
    assign rd_en[i]  =  mode_q[i] | (dir_q[2*i +: 2] == 2'b10);
  end

  assign in_vis     = sync2_q & rd_en;
  assign pad_out    = out_q;
  assign pin_periph = mode_q;
  assign pin_func   = fsel_q;

  always_comb begin
    bus_rdata = '0;
    for (int ln = 0; ln < 2; ln++) begin
      if (in_rng(ba[ln], DIR_BASE, 2*NPORT))
        bus_rdata[ln*8 +: 8] = dir_q[(ba[ln]-DIR_BASE)*8 +: 8];
      else if (in_rng(ba[ln], OUT_BASE, NPORT))
        bus_rdata[ln*8 +: 8] = out_q[(ba[ln]-OUT_BASE)*8 +: 8];
      else if (in_rng(ba[ln], IN_BASE, NPORT))
        bus_rdata[ln*8 +: 8] = in_vis[(ba[ln]-IN_BASE)*8 +: 8];
      else if (in_rng(ba[ln], MODE_BASE, NPORT))
        bus_rdata[ln*8 +: 8] = mode_q[(ba[ln]-MODE_BASE)*8 +: 8];
      else if (in_rng(ba[ln], FSEL_BASE, NPIN))
        bus_rdata[ln*8 +: 8] = fsel_q[(ba[ln]-FSEL_BASE)*8 +: 8];
      else if (ba[ln] == WP_ADDR)
        bus_rdata[ln*8 +: 8] = {b0wi_q, pfswe_q, 6'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      mode_q  <= '0;
      fsel_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      b0wi_q  <= 1'b1;
      pfswe_q <= 1'b0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (bus_we) begin
        for (int ln = 0; ln < 2; ln++) begin
          if (bus_be[ln]) begin
            if (in_rng(ba[ln], DIR_BASE, 2*NPORT))
              dir_q[(ba[ln]-DIR_BASE)*8 +: 8] <= bus_wdata[ln*8 +: 8];
            else if (in_rng(ba[ln], OUT_BASE, NPORT))
              out_q[(ba[ln]-OUT_BASE)*8 +: 8] <= bus_wdata[ln*8 +: 8];
            else if (in_rng(ba[ln], MODE_BASE, NPORT))
              mode_q[(ba[ln]-MODE_BASE)*8 +: 8] <= bus_wdata[ln*8 +: 8];
            else if (in_rng(ba[ln], FSEL_BASE, NPIN)) begin
              if (pfswe_q)
                fsel_q[(ba[ln]-FSEL_BASE)*8 +: 8] <= bus_wdata[ln*8 +: 8];
            end else if (ba[ln] == WP_ADDR) begin
              b0wi_q <= bus_wdata[ln*8 + 7];
              if (!b0wi_q)
                pfswe_q <= bus_wdata[ln*8 + 6];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/pinfunc_ctrl_chk.sv
module pinfunc_ctrl_chk #(
  parameter int NPIN = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [10:0]       bus_addr,
  input logic              bus_we,
  input logic              be_hi,
  input logic              wd7,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pin_periph,
  input logic [8*NPIN-1:0] pin_func,
  input logic              b0wi_q,
  input logic              pfswe_q
);
  p_oe_vs_periph_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pin_periph) == '0);

  p_fsel_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pfswe_q |=> $stable(pin_func));

  p_lock_blocks_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (b0wi_q && !pfswe_q) |=> !pfswe_q);

  p_lock_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && be_hi && bus_addr == 11'h17F) |=> (b0wi_q == $past(wd7)));
endmodule

bind pinfunc_ctrl pinfunc_ctrl_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .be_hi(bus_be[1]), .wd7(bus_wdata[15]), .pad_oe(pad_oe),
  .pin_periph(pin_periph), .pin_func(pin_func),
  .b0wi_q(b0wi_q), .pfswe_q(pfswe_q)
);

// File: tb/pinfunc_ctrl_bench.sv
`timescale 1ns/1ps
module pinfunc_ctrl_bench;
  localparam int NPORT = 3;
  localparam int NPIN  = NPORT * 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [10:0]       bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [1:0]        bus_be = '0;
  logic [15:0]       bus_wdata = '0;
  logic [15:0]       bus_rdata;
  logic [NPIN-1:0]   pad_in = '0;
  logic [NPIN-1:0]   pad_out, pad_oe, pin_periph;
  logic [8*NPIN-1:0] pin_func;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pinfunc_ctrl #(.NPORT(NPORT)) u_pinfunc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pin_periph(pin_periph), .pin_func(pin_func)
  );

  // {byte addr[11:0], strobes[1:0], write data[15:0], expected read[15:0]}
  localparam logic [45:0] VEC [8] = '{
    {12'h000, 2'b11, 16'hFFB3, 16'hFFB3},  // R3 port0 direction
    {12'h004, 2'b11, 16'h1234, 16'h1234},  // R3 port2 direction
    {12'h040, 2'b11, 16'h5AA5, 16'h5AA5},  // R9 ports 0/1 output data
    {12'h042, 2'b01, 16'hFF3C, 16'h003C},  // R9 port2, odd byte unmapped
    {12'h080, 2'b10, 16'h7700, 16'h7700},  // R8 mode port1 only
    {12'h006, 2'b11, 16'hBEEF, 16'h0000},  // R10 first direction byte past last port
    {12'h300, 2'b11, 16'h1111, 16'h0000},  // R10 unmapped
    {12'h200, 2'b11, 16'h4142, 16'h0000}   // R5 function codes while locked
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    bus_addr = a[11:1]; bus_be = be; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a[11:1];
    #1 v = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        total++; bad++;
        $display("FAIL watchdog got=%0d exp=<20000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v;
    do_reset();

    // R1 reset state
    rd(12'h000, v); chk("R1 dir", v, 16'h0000);
    rd(12'h2FE, v); chk("R1 protect", v, 16'h8000);
    rd(12'h040, v); chk("R1 out", v, 16'h0000);
    chk("R1 oe", pad_oe, '0);
    chk("R1 periph", pin_periph, '0);
    chk("R1 func", pin_func[31:0], '0);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][45:34], VEC[i][33:32], VEC[i][31:16]);
      rd(VEC[i][45:34], v);
      chk($sformatf("R3/R5/R8/R9/R10 vector %0d", i), v, VEC[i][15:0]);
    end
    rd(12'h000, v); chk("R10 dir port0 untouched", v, 16'hFFB3);
    rd(12'h080, v); chk("R8 mode port0 lane untouched", v, 16'h7700);

    do_reset();

    // R6 / R7 protect sequencing
    wr(12'h2FE, 2'b10, 16'h4000);
    rd(12'h2FE, v); chk("R6 enable blocked by lock", v, 16'h0000);
    wr(12'h2FE, 2'b10, 16'h4000);
    rd(12'h2FE, v); chk("R7 unlock", v, 16'h4000);
    wr(12'h20A, 2'b01, 16'h0045);
    rd(12'h20A, v); chk("R11 func readback", v, 16'h0045);
    chk("R11 pin_func", pin_func[10*8 +: 8], 8'h45);
    wr(12'h2FE, 2'b10, 16'h0000);
    wr(12'h2FE, 2'b10, 16'h8000);
    rd(12'h2FE, v); chk("R7 relock", v, 16'h8000);
    wr(12'h20A, 2'b01, 16'h0099);
    rd(12'h20A, v); chk("R5 locked write dropped", v, 16'h0045);
    wr(12'h2FE, 2'b10, 16'hC000);
    rd(12'h2FE, v); chk("R6 lock held enable", v, 16'h8000);

    // R8 / R2 mode and output enable on pin 10 (port1 bit2)
    wr(12'h002, 2'b01, 16'h0030);
    chk("R2 oe when output", pad_oe[10], 1'b1);
    wr(12'h080, 2'b10, 16'h0400);
    #1;
    chk("R8 periph", pin_periph[10], 1'b1);
    chk("R8 oe low in periph", pad_oe[10], 1'b0);
    chk("R8 func", pin_func[10*8 +: 8], 8'h45);
    wr(12'h080, 2'b10, 16'h0000);
    chk("R2 oe back", pad_oe[10], 1'b1);
    wr(12'h040, 2'b10, 16'h0400);
    chk("R2 pad_out", pad_out[10], 1'b1);

    // R4 input path
    @(negedge clk); pad_in[10] = 1'b1;
    repeat (3) @(negedge clk);
    rd(12'h060, v); chk("R4 blocked when output", v, 16'h0000);
    wr(12'h002, 2'b01, 16'h0020);
    rd(12'h060, v); chk("R4 input visible", v, 16'h0400);
    @(negedge clk); pad_in[10] = 1'b0;
    rd(12'h060, v); chk("R4 one flop only", v, 16'h0400);
    rd(12'h060, v); chk("R4 after two flops", v, 16'h0000);
    @(negedge clk); pad_in[9] = 1'b1;
    repeat (3) @(negedge clk);
    rd(12'h060, v); chk("R4 idle pin reads 0", v, 16'h0000);
    wr(12'h080, 2'b10, 16'h0200);
    rd(12'h060, v); chk("R4 periph pin visible", v, 16'h0200);
    wr(12'h060, 2'b11, 16'hFFFF);
    rd(12'h060, v); chk("R4 write ignored", v, 16'h0200);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule